// File: doc/BRIEF.md
# I2C Memory-Device Transaction Sequencer

This block runs whole transactions against EEPROM-style devices on an I2C bus. It sits above a bit-level engine and issues one command at a time to it: generate a START, generate a STOP, shift out a byte and return the acknowledge, or shift in a byte and answer it with an acknowledge level. Software-level knowledge of the transaction lives here: the device-address byte, an internal register address of zero to four bytes sent high byte first, the turnaround between addressing and reading, and the acknowledge policy for read data.

A caller starts a transaction with a one-cycle request that carries the kind (probe, read or write), the 7-bit device address, the internal address, its length in bytes and the data length. Write data is pulled a byte at a time from an input port and read data is pushed a byte at a time to an output port. At the end a one-cycle done pulse carries a status code and a count of data bytes the device refused. An optional mask folds internal-address bits that lie above the transmitted address bytes into the low bits of the device address, so a part with more than 256 bytes per address byte appears as several devices.

Top module: `mem_xact_seq`

## Requirements
- R1: A probe (req_kind 2'b00) issues START, the byte {device,0}, then STOP; status is 0 when that byte is acknowledged and 1 when it is refused.
- R2: For a read (req_kind 2'b01) with nonzero address length, or any write (req_kind 2'b10 or 2'b11), the block issues START, {device,0}, then the address bytes from the most significant transmitted byte down to byte 0. Command codes on cmd_op: 0 START, 1 STOP, 2 write byte, 3 read byte.
- R3: A read with address length 0 sends no write-addressing bytes: START is followed at once by {device,1}.
- R4: Between addressing and reading, a STOP then a START is issued when cfg_rep_start is 0; only a START when it is 1.
- R5: Each read byte is requested with cmd_nack 0 except the last, which uses cmd_nack 1; STOP follows. Each byte returned by the engine appears on rd_data with a rd_valid pulse, in order.
- R6: A refused {device,0} byte in a read or write is followed by STOP and status 1.
- R7: A refused address byte is followed by STOP and status 2; no further bytes are sent.
- R8: In the write data phase every byte is sent even when refused; refusals are counted in fail_cnt and status is 3 when the count is nonzero, 0 otherwise. wr_take pulses once per data byte as it is issued.
- R9: Bits of the internal address above the transmitted address bytes, masked by cfg_ovf_mask, are ORed into the low bits of the device address.
- R10: The acknowledge of the {device,1} byte is ignored; the read proceeds either way.
- R11: done is a one-cycle pulse with status and fail_cnt valid; requests arriving while busy are ignored; at most one command is outstanding.
- R12: After reset the block is idle with no command, no done, status 0 and fail_cnt 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a transaction (taken only while idle) |
| req_kind | input | 2 | 00 probe, 01 read, 1x write |
| req_dev | input | 7 | 7-bit device address |
| req_addr | input | 8*ADDR_BYTES | Internal memory address |
| req_alen | input | clog2(ADDR_BYTES+1) | Address bytes to send, 0..ADDR_BYTES |
| req_len | input | LEN_W | Data bytes to read or write |
| cfg_rep_start | input | 1 | 1 selects repeated START before a read |
| cfg_ovf_mask | input | OVF_W | Mask of folded high address bits |
| busy | output | 1 | Transaction in progress |
| cmd_valid | output | 1 | One-cycle command to the bit engine |
| cmd_op | output | 2 | Command code |
| cmd_byte | output | 8 | Byte to shift out |
| cmd_nack | output | 1 | Acknowledge level for a read byte (1 = refuse) |
| eng_done | input | 1 | Engine finished the outstanding command |
| eng_nack | input | 1 | Byte write was refused |
| eng_rdata | input | 8 | Byte read by the engine |
| wr_data | input | 8 | Next write data byte |
| wr_take | output | 1 | wr_data consumed this cycle |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | rd_data valid |
| done | output | 1 | Transaction finished |
| status | output | 2 | 0 ok, 1 no device, 2 address refused, 3 data refusals |
| fail_cnt | output | CNT_W | Refused write data bytes (saturating) |

## Verification
Each command is raised for one cycle in the cycle after the engine reports completion of the previous one; a read byte appears on rd_data one cycle after the engine completes it, and done rises one cycle after the engine completes the closing STOP. The bench's engine model answers two cycles after each command, logs every command at the falling edge it is visible on, and the main sequence samples done, status, fail_cnt and the read bytes at falling edges as well, so each result is read in the cycle it is due. Each transaction's full command trace is compared against a trace rebuilt from the requirements.

// File: rtl/mem_xact_seq.sv
module mem_xact_seq #(
  parameter int ADDR_BYTES = 4,
  parameter int LEN_W = 8,
  parameter int OVF_W = 3,
  parameter int CNT_W = 8,
  localparam int AW = 8 * ADDR_BYTES,
  localparam int AL_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic [6:0]       req_dev,
  input  logic [AW-1:0]    req_addr,
  input  logic [AL_W-1:0]  req_alen,
  input  logic [LEN_W-1:0] req_len,
  input  logic             cfg_rep_start,
  input  logic [OVF_W-1:0] cfg_ovf_mask,
  output logic             busy,
  output logic             cmd_valid,
  output logic [1:0]       cmd_op,
  output logic [7:0]       cmd_byte,
  output logic             cmd_nack,
  input  logic             eng_done,
  input  logic             eng_nack,
  input  logic [7:0]       eng_rdata,
  input  logic [7:0]       wr_data,
  output logic             wr_take,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             done,
  output logic [1:0]       status,
  output logic [CNT_W-1:0] fail_cnt
);

  typedef enum logic [3:0] {
    PH_IDLE, PH_START1, PH_DEVW, PH_ADDR, PH_TSTOP,
    PH_START2, PH_DEVR, PH_RDATA, PH_WDATA, PH_STOP
  } phase_t;

  phase_t           ph_q;
  logic             wait_q;
  logic [1:0]       kind_q;
  logic [6:0]       dev_q;
  logic [AW-1:0]    addr_q;
  logic [AL_W-1:0]  alen_q;
  logic [AL_W-1:0]  idx_q;
  logic [LEN_W-1:0] rem_q;
  logic             rep_q;
  logic [OVF_W-1:0] mask_q;
  logic [1:0]       stat_q;
  logic [CNT_W-1:0] fail_q;

  logic             step;
  logic             is_wr;
  logic             is_probe;
  logic             last_byte;
  logic [OVF_W-1:0] ovf_bits;
  logic [6:0]       dev_eff;
  logic [7:0]       addr_byte;

  assign step      = wait_q && eng_done;
  assign is_wr     = kind_q[1];
  assign is_probe  = (kind_q == 2'b00);
  assign last_byte = (rem_q == LEN_W'(1));
  assign busy      = (ph_q != PH_IDLE);
  assign cmd_valid = busy && !wait_q;
  assign wr_take   = cmd_valid && (ph_q == PH_WDATA);
  assign cmd_nack  = (ph_q == PH_RDATA) && last_byte;
  assign fail_cnt  = fail_q;

  assign ovf_bits  = OVF_W'(addr_q >> {alen_q, 3'b000}) & mask_q;
  assign dev_eff   = dev_q | 7'(ovf_bits);
  assign addr_byte = 8'(addr_q >> {idx_q, 3'b000});

  always_comb begin
    cmd_op   = 2'd0;
    cmd_byte = 8'h00;
    case (ph_q)
      PH_TSTOP, PH_STOP: cmd_op = 2'd1;
      PH_DEVW: begin cmd_op = 2'd2; cmd_byte = {dev_eff, 1'b0}; end
      PH_DEVR: begin cmd_op = 2'd2; cmd_byte = {dev_eff, 1'b1}; end
      PH_ADDR: begin cmd_op = 2'd2; cmd_byte = addr_byte; end
      PH_WDATA: begin cmd_op = 2'd2; cmd_byte = wr_data; end
      PH_RDATA: cmd_op = 2'd3;
      default: cmd_op = 2'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      wait_q   <= 1'b0;
      kind_q   <= 2'b00;
      dev_q    <= '0;
      addr_q   <= '0;
      alen_q   <= '0;
      idx_q    <= '0;
      rem_q    <= '0;
      rep_q    <= 1'b0;
      mask_q   <= '0;
      stat_q   <= 2'd0;
      fail_q   <= '0;
      done     <= 1'b0;
      status   <= 2'd0;
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end else begin
      done     <= 1'b0;
      rd_valid <= 1'b0;
      if (cmd_valid) wait_q <= 1'b1;
      else if (step) wait_q <= 1'b0;

      if (ph_q == PH_IDLE) begin
        if (req_valid) begin
          kind_q <= req_kind;
          dev_q  <= req_dev;
          addr_q <= req_addr;
          alen_q <= req_alen;
          rem_q  <= req_len;
          rep_q  <= cfg_rep_start;
          mask_q <= cfg_ovf_mask;
          stat_q <= 2'd0;
          fail_q <= '0;
          ph_q   <= PH_START1;
        end
      end else if (step) begin
        case (ph_q)
          PH_START1:
            ph_q <= (kind_q == 2'b01 && alen_q == '0) ? PH_DEVR : PH_DEVW;
          PH_DEVW: begin
            if (eng_nack) begin
              stat_q <= 2'd1;
              ph_q   <= PH_STOP;
            end else if (is_probe) begin
              ph_q <= PH_STOP;
            end else if (alen_q != '0) begin
              idx_q <= alen_q - AL_W'(1);
              ph_q  <= PH_ADDR;
            end else begin
              ph_q <= (rem_q == '0) ? PH_STOP : PH_WDATA;
            end
          end
          PH_ADDR: begin
            if (eng_nack) begin
              stat_q <= 2'd2;
              ph_q   <= PH_STOP;
            end else if (idx_q != '0) begin
              idx_q <= idx_q - AL_W'(1);
            end else if (is_wr) begin
              ph_q <= (rem_q == '0) ? PH_STOP : PH_WDATA;
            end else begin
              ph_q <= rep_q ? PH_START2 : PH_TSTOP;
            end
          end
          PH_TSTOP:  ph_q <= PH_START2;
          PH_START2: ph_q <= PH_DEVR;
          PH_DEVR:   ph_q <= (rem_q == '0) ? PH_STOP : PH_RDATA;
          PH_RDATA: begin
            rd_valid <= 1'b1;
            rd_data  <= eng_rdata;
            rem_q    <= rem_q - LEN_W'(1);
            if (last_byte) ph_q <= PH_STOP;
          end
          PH_WDATA: begin
            if (eng_nack && fail_q != '1) fail_q <= fail_q + CNT_W'(1);
            rem_q <= rem_q - LEN_W'(1);
            if (last_byte) ph_q <= PH_STOP;
          end
          PH_STOP: begin
            done   <= 1'b1;
            status <= (stat_q == 2'd0 && fail_q != '0) ? 2'd3 : stat_q;
            ph_q   <= PH_IDLE;
          end
          default: ph_q <= PH_IDLE;
        endcase
      end
    end
  end

endmodule

module mem_xact_seq_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             cmd_valid,
  input logic [1:0]       cmd_op,
  input logic             wr_take,
  input logic             eng_done,
  input logic             rd_valid,
  input logic             done,
  input logic [1:0]       status,
  input logic [CNT_W-1:0] fail_cnt
);

  // R11
  single_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8
  take_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> (cmd_valid && cmd_op == 2'd2));

  // R8
  fail_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 2'd3) |-> (fail_cnt != '0));

  // R5
  rd_after_engine_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(eng_done));

endmodule

bind mem_xact_seq mem_xact_seq_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cmd_valid(cmd_valid),
  .cmd_op(cmd_op), .wr_take(wr_take), .eng_done(eng_done),
  .rd_valid(rd_valid), .done(done), .status(status), .fail_cnt(fail_cnt)
);

// File: tb/mem_xact_seq_tb_top.sv
`timescale 1ns/1ps
module mem_xact_seq_tb_top;

  typedef struct packed {
    logic [1:0]  kind;
    logic [6:0]  dev;
    logic [31:0] addr;
    logic [2:0]  alen;
    logic [7:0]  len;
    logic        rep;
    logic [2:0]  mask;
    logic [15:0] nackm;
    logic [1:0]  st;
    logic [7:0]  fail;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 7'h50, 32'h0,        3'd0, 8'd0, 1'b0, 3'd0, 16'h0000, 2'd0, 8'd0},
    '{2'd0, 7'h51, 32'h0,        3'd0, 8'd0, 1'b0, 3'd0, 16'h0001, 2'd1, 8'd0},
    '{2'd1, 7'h50, 32'h0123,     3'd2, 8'd3, 1'b0, 3'd0, 16'h0000, 2'd0, 8'd0},
    '{2'd1, 7'h50, 32'h45,       3'd1, 8'd2, 1'b1, 3'd0, 16'h0000, 2'd0, 8'd0},
    '{2'd1, 7'h50, 32'h0,        3'd0, 8'd2, 1'b0, 3'd0, 16'h0001, 2'd0, 8'd0},
    '{2'd2, 7'h50, 32'h0A0B,     3'd2, 8'd3, 1'b0, 3'd0, 16'h0028, 2'd3, 8'd2},
    '{2'd2, 7'h50, 32'h77,       3'd1, 8'd2, 1'b0, 3'd0, 16'h0008, 2'd3, 8'd1},
    '{2'd2, 7'h53, 32'h10,       3'd1, 8'd2, 1'b0, 3'd0, 16'h0001, 2'd1, 8'd0},
    '{2'd1, 7'h50, 32'h0304,     3'd2, 8'd1, 1'b0, 3'd0, 16'h0004, 2'd2, 8'd0},
    '{2'd1, 7'h50, 32'h02C7,     3'd1, 8'd1, 1'b0, 3'd3, 16'h0000, 2'd0, 8'd0},
    '{2'd2, 7'h50, 32'h0,        3'd0, 8'd2, 1'b0, 3'd0, 16'h0000, 2'd0, 8'd0},
    '{2'd1, 7'h50, 32'h11223344, 3'd4, 8'd1, 1'b1, 3'd0, 16'h0000, 2'd0, 8'd0},
    '{2'd3, 7'h50, 32'h0506,     3'd2, 8'd1, 1'b0, 3'd0, 16'h0002, 2'd2, 8'd0},
    '{2'd2, 7'h50, 32'h9A,       3'd1, 8'd0, 1'b0, 3'd0, 16'h0000, 2'd0, 8'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic [6:0]  req_dev = 7'h0;
  logic [31:0] req_addr = 32'h0;
  logic [2:0]  req_alen = 3'd0;
  logic [7:0]  req_len = 8'd0;
  logic        cfg_rep_start = 1'b0;
  logic [2:0]  cfg_ovf_mask = 3'd0;
  logic        busy, cmd_valid, cmd_nack, wr_take, rd_valid, done;
  logic [1:0]  cmd_op, status;
  logic [7:0]  cmd_byte, rd_data, fail_cnt;
  logic        eng_done = 1'b0;
  logic        eng_nack = 1'b0;
  logic [7:0]  eng_rdata = 8'h00;
  logic [7:0]  wr_data;

  always #2 clk = ~clk;

  mem_xact_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_dev(req_dev), .req_addr(req_addr), .req_alen(req_alen),
    .req_len(req_len), .cfg_rep_start(cfg_rep_start),
    .cfg_ovf_mask(cfg_ovf_mask), .busy(busy), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_nack(cmd_nack),
    .eng_done(eng_done), .eng_nack(eng_nack), .eng_rdata(eng_rdata),
    .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data),
    .rd_valid(rd_valid), .done(done), .status(status), .fail_cnt(fail_cnt)
  );

  int nchk = 0;
  int nbad = 0;
  bit hung = 1'b0;

  logic [10:0] log_q [64];
  logic [10:0] exp_q [64];
  logic [7:0]  rd_got [64];
  int log_n = 0, exp_n = 0, rd_n = 0, wr_idx = 0, wcnt = 0, rcnt = 0;
  int eng_cnt = 0;
  logic [15:0] cur_nackm = 16'h0;
  logic        pend_nack = 1'b0;
  logic [7:0]  pend_rdata = 8'h00;

  assign wr_data = 8'h30 + 8'(wr_idx);

  // bit engine model: answers two cycles after each command
  always @(negedge clk) begin
    eng_done = 1'b0;
    if (eng_cnt > 0) begin
      eng_cnt--;
      if (eng_cnt == 0) begin
        eng_done  = 1'b1;
        eng_nack  = pend_nack;
        eng_rdata = pend_rdata;
      end
    end
    if (rd_valid) begin
      rd_got[rd_n] = rd_data;
      rd_n++;
    end
    if (cmd_valid) begin
      log_q[log_n] = {cmd_op, (cmd_op == 2'd2) ? cmd_byte : 8'h00,
                      (cmd_op == 2'd3) ? cmd_nack : 1'b0};
      if (log_n < 63) log_n++;
      pend_nack = 1'b0;
      if (cmd_op == 2'd2) begin
        pend_nack = (wcnt < 16) ? cur_nackm[wcnt] : 1'b0;
        wcnt++;
      end
      if (cmd_op == 2'd3) begin
        pend_rdata = 8'hA0 + 8'(rcnt);
        rcnt++;
      end
      if (wr_take) wr_idx++;
      eng_cnt = 2;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, expv);
    end
  endtask

  task automatic push(input logic [1:0] op, input logic [7:0] b, input logic a);
    exp_q[exp_n] = {op, b, a};
    exp_n++;
  endtask

  task automatic build_exp(input vec_t v);
    logic [31:0] hi;
    logic [6:0]  devf;
    int wi;
    exp_n = 0;
    wi = 0;
    hi = (v.alen >= 3'd4) ? 32'h0 : (v.addr >> (8 * int'(v.alen)));
    devf = v.dev | {4'b0000, hi[2:0] & v.mask};
    push(2'd0, 8'h00, 1'b0);
    if (!(v.kind == 2'd1 && v.alen == 3'd0)) begin
      push(2'd2, {devf, 1'b0}, 1'b0);
      if (v.nackm[wi]) begin push(2'd1, 8'h00, 1'b0); return; end
      wi++;
      if (v.kind == 2'd0) begin push(2'd1, 8'h00, 1'b0); return; end
      for (int k = int'(v.alen) - 1; k >= 0; k--) begin
        push(2'd2, v.addr[8*k +: 8], 1'b0);
        if (v.nackm[wi]) begin push(2'd1, 8'h00, 1'b0); return; end
        wi++;
      end
      if (v.kind[1]) begin
        for (int d = 0; d < int'(v.len); d++) push(2'd2, 8'h30 + 8'(d), 1'b0);
        push(2'd1, 8'h00, 1'b0);
        return;
      end
      if (!v.rep) push(2'd1, 8'h00, 1'b0);
      push(2'd0, 8'h00, 1'b0);
    end
    push(2'd2, {devf, 1'b1}, 1'b0);
    for (int d = 0; d < int'(v.len); d++)
      push(2'd3, 8'h00, (d == int'(v.len) - 1));
    push(2'd1, 8'h00, 1'b0);
  endtask

  task automatic start_req(input vec_t v);
    log_n = 0; rd_n = 0; wr_idx = 0; wcnt = 0; rcnt = 0;
    cur_nackm = v.nackm;
    req_kind = v.kind; req_dev = v.dev; req_addr = v.addr;
    req_alen = v.alen; req_len = v.len; cfg_rep_start = v.rep;
    cfg_ovf_mask = v.mask;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    int t;
    t = 0;
    while (!done && t < 3000) begin
      @(negedge clk);
      t++;
    end
    if (!done) begin
      hung = 1'b1;
      chk(1'b0, "watchdog R11", 32'(t), 32'd3000);
    end
  endtask

  task automatic check_vec(input vec_t v, input string tag);
    bit same;
    int bad_i;
    chk(status == v.st, {tag, " status"}, 32'(status), 32'(v.st));
    chk(fail_cnt == v.fail, {tag, " R8 fail_cnt"}, 32'(fail_cnt), 32'(v.fail));
    build_exp(v);
    same = (log_n == exp_n);
    bad_i = 0;
    for (int i = 0; i < exp_n && same; i++)
      if (log_q[i] !== exp_q[i]) begin same = 1'b0; bad_i = i; end
    if (log_n != exp_n)
      chk(1'b0, {tag, " command count"}, 32'(log_n), 32'(exp_n));
    else
      chk(same, {tag, " command trace"}, 32'(log_q[bad_i]), 32'(exp_q[bad_i]));
    if (v.kind == 2'd1 && v.st == 2'd0) begin
      same = (rd_n == int'(v.len));
      for (int i = 0; i < rd_n && same; i++)
        if (rd_got[i] !== 8'hA0 + 8'(i)) same = 1'b0;
      chk(same, {tag, " R5 read data"}, 32'(rd_n), 32'(v.len));
    end
  endtask

  string vtag [NV];

  initial begin
    vtag = '{"R1 present", "R1 absent", "R2 two-byte read", "R4 repeated start",
             "R3 R10 no-address read", "R8 write refusals", "R8 last refused",
             "R6 write no device", "R7 read address refused", "R9 fold",
             "R8 no-address write", "R5 R4 four-byte read", "R7 write address refused",
             "R2 empty write"};
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!busy && !cmd_valid && !done, "R12 idle after reset",
        {29'd0, busy, cmd_valid, done}, 32'd0);
    chk(status == 2'd0 && fail_cnt == 8'd0, "R12 status after reset",
        {22'd0, status, fail_cnt}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int n = 0; n < NV && !hung; n++) begin
      start_req(VECS[n]);
      wait_done();
      if (!hung) check_vec(VECS[n], vtag[n]);
      @(negedge clk);
      // R11 done lasts one cycle
      chk(!done, "R11 done pulse", 32'(done), 32'd0);
      repeat (2) @(negedge clk);
    end

    if (!hung) begin
      // R11 request while busy is ignored
      start_req(VECS[2]);
      repeat (5) @(negedge clk);
      req_kind = 2'd0; req_dev = 7'h22; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      req_kind = 2'd1; req_dev = 7'h50;
      wait_done();
      if (!hung) check_vec(VECS[2], "R11 busy ignore");
      repeat (20) @(negedge clk);
      chk(!busy && log_n == exp_n, "R11 no late start", 32'(log_n), 32'(exp_n));
    end

    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule